// File: doc/BRIEF.md
# Dual-Mode Digital AGC Loop

This block closes a gain-control loop around a complex baseband stream. Each time an upstream stage presents a new magnitude sample with a valid strobe, the loop compares it against a programmable target level. It then moves a gain accumulator held in decibels with 1/64 dB resolution over a 0 to 96 dB span. The accumulator drives a gain bus toward the multiplier that scales the I/Q samples. That multiplier and the magnitude estimator are separate blocks.

Two settling behaviours are available. In proportional mode the error (target minus magnitude) is multiplied by a loop gain and added to the accumulator, so the gain converges asymptotically. In sign-only mode every strobe moves the gain by a fixed step, up or down by the sign of the error, which makes settling time independent of signal level at the cost of a one-step dither. Two loop-gain registers exist, one for fast acquisition at the start of a burst and one for slow tracking, chosen by an input pin. A pair of limit registers clamps the accumulator, and setting both to the same value freezes the gain.

Top module: `agc_loop`

## Requirements
- R1: After reset the gain output is 0, the target is 16384, the fast loop gain is 64, the tracking loop gain is 8, the lower limit is 0, the upper limit is 6144 and sign-only mode is selected.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the clock edge. The address map is 0 target, 1 fast loop gain (low 8 bits), 2 tracking loop gain (low 8 bits), 3 lower limit, 4 upper limit, 5 mode (bit 0: 0 sign-only, 1 proportional). Writes to addresses 6 and 7 change nothing.
- R3: In sign-only mode a strobe adds the step when the magnitude is below the target, subtracts it when above, and leaves the gain unchanged when equal.
- R4: The sign-only step equals the selected loop gain but never exceeds 192 (3 dB).
- R5: In proportional mode a strobe adds floor((target - magnitude) * loop_gain / 256) to the gain.
- R6: `gain_sel` low selects the fast loop gain and high selects the tracking loop gain, sampled at the strobe.
- R7: After each update the result is limited to at most the upper limit and then to at least the lower limit, in the same cycle, so a lower limit above the upper limit yields the lower limit.
- R8: With both limits equal, every strobe sets the gain to that value.
- R9: Without a strobe the gain does not change, whatever the magnitude.
- R10: Limit writes above 6144 (96 dB) are stored as 6144, and the gain never exceeds 6144.
- R11: The gain output shows the effect of a strobe in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| sample_valid | input | 1 | Strobe: `mag_in` holds a new sample |
| mag_in | input | 16 | Unsigned signal magnitude |
| gain_sel | input | 1 | Loop-gain select (0 fast, 1 tracking) |
| gain_db | output | 13 | Gain in 1/64 dB units, 0 to 6144 |

## Verification
The bench drives proportional updates whose product is not a multiple of 256 and negative, so a design that truncates toward zero instead of flooring moves the gain one count too far. It programs a sign-only step above 3 dB, where a missing cap overshoots. It also drives a zero error, where a design that treats zero as negative dithers downward. It inverts the limits and equalises them; a design that clamps in the other order settles on the upper limit. It writes out-of-range limits, which would otherwise allow a gain beyond 96 dB, and it writes unused addresses, which a loose decoder would alias onto a loop gain. A long random run with mixed modes and strobes is compared against the behavioural model on every clock.

// File: rtl/agc_pkg.sv
package agc_pkg;

  localparam int CFG_ADDR_W = 3;

  typedef enum logic [CFG_ADDR_W-1:0] {
    ADDR_TARGET   = 3'd0,
    ADDR_LG_FAST  = 3'd1,
    ADDR_LG_TRACK = 3'd2,
    ADDR_LIM_LO   = 3'd3,
    ADDR_LIM_HI   = 3'd4,
    ADDR_MODE     = 3'd5
  } cfg_addr_e;

  typedef enum logic {
    SETTLE_SIGN = 1'b0,
    SETTLE_PROP = 1'b1
  } settle_mode_e;

endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
  import agc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int MAG_W        = 16,
  parameter int LG_W         = 8,
  parameter int GAIN_W       = 13,
  parameter int GAIN_MAX     = 6144,
  parameter int TARGET_DEF   = 16384,
  parameter int LG_FAST_DEF  = 64,
  parameter int LG_TRACK_DEF = 8,
  parameter int LIM_LO_DEF   = 0,
  parameter int LIM_HI_DEF   = 6144
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [MAG_W-1:0]      target,
  output logic [LG_W-1:0]       lg_fast,
  output logic [LG_W-1:0]       lg_track,
  output logic [GAIN_W-1:0]     lim_lo,
  output logic [GAIN_W-1:0]     lim_hi,
  output settle_mode_e          mode
);

  localparam int NUM_LG = 2;
  localparam logic [DATA_W-1:0] GAIN_MAX_D = DATA_W'(GAIN_MAX);

  // Limit writes saturate at the top of the gain span.
  function automatic logic [GAIN_W-1:0] sat_limit(input logic [DATA_W-1:0] v);
    if (v > GAIN_MAX_D) return GAIN_W'(GAIN_MAX);
    return v[GAIN_W-1:0];
  endfunction

  logic hit_target, hit_lo, hit_hi, hit_mode;
  logic [MAG_W-1:0]  target_q, target_d;
  logic [GAIN_W-1:0] lo_q, lo_d, hi_q, hi_d;
  settle_mode_e      mode_q, mode_d;

  // ---------------- next state ----------------
  always_comb begin
    hit_target = cfg_we && (cfg_addr == ADDR_TARGET);
    hit_lo     = cfg_we && (cfg_addr == ADDR_LIM_LO);
    hit_hi     = cfg_we && (cfg_addr == ADDR_LIM_HI);
    hit_mode   = cfg_we && (cfg_addr == ADDR_MODE);
    target_d   = hit_target ? cfg_wdata[MAG_W-1:0] : target_q;
    lo_d       = hit_lo ? sat_limit(cfg_wdata) : lo_q;
    hi_d       = hit_hi ? sat_limit(cfg_wdata) : hi_q;
    mode_d     = hit_mode ? settle_mode_e'(cfg_wdata[0]) : mode_q;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= MAG_W'(TARGET_DEF);
    end else if (hit_target) begin
      target_q <= target_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= GAIN_W'(LIM_LO_DEF);
    end else if (hit_lo) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= GAIN_W'(LIM_HI_DEF);
    end else if (hit_hi) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SETTLE_SIGN;
    end else if (hit_mode) begin
      mode_q <= mode_d;
    end
  end

  // Loop-gain bank: one register slot per selectable loop gain.
  for (genvar g = 0; g < NUM_LG; g++) begin : g_lg
    localparam logic [CFG_ADDR_W-1:0] SLOT = (g == 0) ? ADDR_LG_FAST : ADDR_LG_TRACK;
    localparam logic [LG_W-1:0] RST_VAL = (g == 0) ? LG_W'(LG_FAST_DEF) : LG_W'(LG_TRACK_DEF);
    logic            hit;
    logic [LG_W-1:0] q, d;

    always_comb begin
      hit = cfg_we && (cfg_addr == SLOT);
      d   = hit ? cfg_wdata[LG_W-1:0] : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (hit) begin
        q <= d;
      end
    end
  end

  assign target   = target_q;
  assign lg_fast  = g_lg[0].q;
  assign lg_track = g_lg[1].q;
  assign lim_lo   = lo_q;
  assign lim_hi   = hi_q;
  assign mode     = mode_q;

endmodule

// File: rtl/agc_err_step.sv
module agc_err_step
  import agc_pkg::*;
#(
  parameter int MAG_W      = 16,
  parameter int LG_W       = 8,
  parameter int MEAN_SHIFT = 8,
  parameter int MAX_STEP   = 192,
  parameter int DELTA_W    = 18
) (
  input  logic [MAG_W-1:0]          target,
  input  logic [MAG_W-1:0]          mag,
  input  logic [LG_W-1:0]           lg,
  input  settle_mode_e              mode,
  output logic signed [DELTA_W-1:0] delta
);

  localparam int ERR_W  = MAG_W + 1;
  localparam int PROD_W = ERR_W + LG_W + 1;
  localparam logic [LG_W-1:0] STEP_CAP = LG_W'(MAX_STEP);

  logic signed [ERR_W-1:0]   err;
  logic signed [PROD_W-1:0]  prod;
  logic [LG_W-1:0]           step_mag;
  logic signed [DELTA_W-1:0] prop_d, sign_d, step_s;

  always_comb begin
    // error = target - magnitude; positive asks for more gain
    err      = $signed({1'b0, target}) - $signed({1'b0, mag});
    prod     = PROD_W'(err) * PROD_W'($signed({1'b0, lg}));
    // arithmetic shift floors toward minus infinity
    prop_d   = DELTA_W'(prod >>> MEAN_SHIFT);

    step_mag = (lg > STEP_CAP) ? STEP_CAP : lg;
    step_s   = $signed(DELTA_W'(step_mag));
    if (err == '0) begin
      sign_d = '0;
    end else if (err[ERR_W-1]) begin
      sign_d = -step_s;
    end else begin
      sign_d = step_s;
    end

    delta = (mode == SETTLE_PROP) ? prop_d : sign_d;
  end

endmodule

// File: rtl/agc_gain_acc.sv
module agc_gain_acc #(
  parameter int GAIN_W    = 13,
  parameter int DELTA_W   = 18,
  parameter int RESET_VAL = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_en,
  input  logic signed [DELTA_W-1:0] delta,
  input  logic [GAIN_W-1:0]         lim_lo,
  input  logic [GAIN_W-1:0]         lim_hi,
  output logic [GAIN_W-1:0]         gain
);

  localparam int EXT_W = ((DELTA_W > GAIN_W) ? DELTA_W : GAIN_W) + 2;

  logic signed [EXT_W-1:0] sum, lo_x, hi_x, clip;
  logic [GAIN_W-1:0]       gain_q, gain_d;

  // ---------------- next state ----------------
  always_comb begin
    lo_x = $signed(EXT_W'(lim_lo));
    hi_x = $signed(EXT_W'(lim_hi));
    sum  = $signed(EXT_W'(gain_q)) + EXT_W'(delta);
    clip = sum;
    // upper bound first, lower bound last: lower limit wins if inverted
    if (clip > hi_x) clip = hi_x;
    if (clip < lo_x) clip = lo_x;
    gain_d = upd_en ? clip[GAIN_W-1:0] : gain_q;
  end

  // ---------------- register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_W'(RESET_VAL);
    end else if (upd_en) begin
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;

endmodule

// File: rtl/agc_loop.sv
module agc_loop
  import agc_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int MAG_W        = 16,
  parameter int LG_W         = 8,
  parameter int GAIN_FRAC    = 6,
  parameter int RANGE_DB     = 96,
  parameter int MEAN_SHIFT   = 8,
  parameter int STEP_CAP_DB  = 3,
  parameter int TARGET_DEF   = 16384,
  parameter int LG_FAST_DEF  = 64,
  parameter int LG_TRACK_DEF = 8,
  parameter int LIM_LO_DEF   = 0,
  localparam int GAIN_MAX    = RANGE_DB << GAIN_FRAC,
  localparam int GAIN_W      = $clog2(GAIN_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  input  logic                  sample_valid,
  input  logic [MAG_W-1:0]      mag_in,
  input  logic                  gain_sel,
  output logic [GAIN_W-1:0]     gain_db
);

  localparam int MAX_STEP = STEP_CAP_DB << GAIN_FRAC;
  localparam int ERR_W    = MAG_W + 1;
  localparam int PROD_W   = ERR_W + LG_W + 1;
  localparam int DELTA_W  = PROD_W - MEAN_SHIFT;

  logic [MAG_W-1:0]          target;
  logic [LG_W-1:0]           lg_fast, lg_track, lg_act;
  logic [GAIN_W-1:0]         lim_lo, lim_hi;
  settle_mode_e              mode_q;
  logic signed [DELTA_W-1:0] delta;

  agc_cfg_regs #(
    .DATA_W      (DATA_W),
    .MAG_W       (MAG_W),
    .LG_W        (LG_W),
    .GAIN_W      (GAIN_W),
    .GAIN_MAX    (GAIN_MAX),
    .TARGET_DEF  (TARGET_DEF),
    .LG_FAST_DEF (LG_FAST_DEF),
    .LG_TRACK_DEF(LG_TRACK_DEF),
    .LIM_LO_DEF  (LIM_LO_DEF),
    .LIM_HI_DEF  (GAIN_MAX)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .target   (target),
    .lg_fast  (lg_fast),
    .lg_track (lg_track),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .mode     (mode_q)
  );

  assign lg_act = gain_sel ? lg_track : lg_fast;

  agc_err_step #(
    .MAG_W     (MAG_W),
    .LG_W      (LG_W),
    .MEAN_SHIFT(MEAN_SHIFT),
    .MAX_STEP  (MAX_STEP),
    .DELTA_W   (DELTA_W)
  ) u_step (
    .target(target),
    .mag   (mag_in),
    .lg    (lg_act),
    .mode  (mode_q),
    .delta (delta)
  );

  agc_gain_acc #(
    .GAIN_W   (GAIN_W),
    .DELTA_W  (DELTA_W),
    .RESET_VAL(LIM_LO_DEF)
  ) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_en(sample_valid),
    .delta (delta),
    .lim_lo(lim_lo),
    .lim_hi(lim_hi),
    .gain  (gain_db)
  );

endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk #(
  parameter int GAIN_W   = 13,
  parameter int GAIN_MAX = 6144,
  parameter int MAX_STEP = 192
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic              mode_prop,
  input logic [GAIN_W-1:0] lim_lo,
  input logic [GAIN_W-1:0] lim_hi,
  input logic [GAIN_W-1:0] gain_db
);

  localparam logic [GAIN_W-1:0] TOP  = GAIN_W'(GAIN_MAX);
  localparam logic [GAIN_W-1:0] STEP = GAIN_W'(MAX_STEP);

  // R9: no strobe, no movement
  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(gain_db));

  // R7: an update lands inside ordered limits
  a_r7_inside_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && (lim_lo <= lim_hi)) |=>
      ((gain_db >= $past(lim_lo)) && (gain_db <= $past(lim_hi))));

  // R8: equal limits pin the gain
  a_r8_frozen_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && (lim_lo == lim_hi)) |=> (gain_db == $past(lim_lo)));

  // R4: sign-only moves never exceed the 3 dB cap
  a_r4_step_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !mode_prop && (gain_db >= lim_lo) && (gain_db <= lim_hi)) |=>
      ((gain_db >= $past(gain_db)) ? ((gain_db - $past(gain_db)) <= STEP)
                                   : (($past(gain_db) - gain_db) <= STEP)));

  // R10: gain stays within the 96 dB span
  a_r10_span: assert property (@(posedge clk) disable iff (!rst_n)
    gain_db <= TOP);

endmodule

bind agc_loop agc_loop_chk #(
  .GAIN_W  (GAIN_W),
  .GAIN_MAX(GAIN_MAX),
  .MAX_STEP(MAX_STEP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_valid(sample_valid),
  .mode_prop   (mode_q == agc_pkg::SETTLE_PROP),
  .lim_lo      (lim_lo),
  .lim_hi      (lim_hi),
  .gain_db     (gain_db)
);

// File: tb/agc_loop_test.sv
module agc_loop_test;

  localparam int GW = 13;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [15:0]   cfg_wdata;
  logic          sample_valid;
  logic [15:0]   mag_in;
  logic          gain_sel;
  logic [GW-1:0] gain_db;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  agc_loop uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sample_valid(sample_valid), .mag_in(mag_in),
    .gain_sel(gain_sel), .gain_db(gain_db)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_tgt, m_lgf, m_lgt, m_lo, m_hi, m_mode, m_gain;
  int e_err, e_lg, e_d, e_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tgt = 16384; m_lgf = 64; m_lgt = 8; m_lo = 0; m_hi = 6144;
      m_mode = 0; m_gain = 0;
    end else begin
      if (sample_valid) begin
        e_lg  = gain_sel ? m_lgt : m_lgf;
        e_err = m_tgt - int'(mag_in);
        if (m_mode == 1) e_d = (e_err * e_lg) >>> 8;
        else begin
          e_d = (e_lg > 192) ? 192 : e_lg;
          if (e_err < 0) e_d = -e_d;
          else if (e_err == 0) e_d = 0;
        end
        e_n = m_gain + e_d;
        if (e_n > m_hi) e_n = m_hi;
        if (e_n < m_lo) e_n = m_lo;
        m_gain = e_n;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_tgt = int'(cfg_wdata);
          3'd1: m_lgf = int'(cfg_wdata[7:0]);
          3'd2: m_lgt = int'(cfg_wdata[7:0]);
          3'd3: m_lo  = (int'(cfg_wdata) > 6144) ? 6144 : int'(cfg_wdata);
          3'd4: m_hi  = (int'(cfg_wdata) > 6144) ? 6144 : int'(cfg_wdata);
          3'd5: m_mode = int'(cfg_wdata[0]);
          default: ;
        endcase
      end
    end
  end

  // Every-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(gain_db) != m_gain) begin
        errors++;
        $display("FAIL %s model compare: actual %0d expected %0d", tag, gain_db, m_gain);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic expect_gain(input string req, input int exp);
    checks++;
    if (int'(gain_db) != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, gain_db, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe(input int m);
    @(negedge clk);
    sample_valid = 1'b1; mag_in = 16'(m);
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 60000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 60000 cycles", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    sample_valid = 1'b0; mag_in = '0; gain_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; expect_gain("R1 reset gain", 0);

    tag = "R3";
    repeat (3) strobe(100);
    expect_gain("R3 three steps up", 192);
    strobe(20000);
    expect_gain("R3 one step down", 128);
    strobe(16384);
    expect_gain("R3 zero error", 128);

    tag = "R4";
    wr(1, 250);
    strobe(0);
    expect_gain("R4 step capped at 192", 320);

    tag = "R6";
    gain_sel = 1'b1;
    strobe(0);
    expect_gain("R6 tracking gain step 8", 328);
    gain_sel = 1'b0;

    tag = "R2";
    wr(7, 0);
    wr(6, 5);
    strobe(0);
    expect_gain("R2 unused addresses ignored", 520);

    tag = "R5";
    wr(5, 1); wr(0, 1000); wr(1, 64);
    strobe(200);
    expect_gain("R5 proportional up", 720);
    strobe(1800);
    expect_gain("R5 proportional down", 520);
    strobe(1001);
    expect_gain("R5 floor of negative fraction", 519);

    tag = "R7";
    wr(4, 600); wr(3, 500);
    strobe(0);
    expect_gain("R7 clamp to upper", 600);
    strobe(5000);
    expect_gain("R7 clamp to lower", 500);
    wr(3, 2000); wr(4, 1500);
    strobe(1000);
    expect_gain("R7 inverted limits give lower", 2000);

    tag = "R8";
    wr(3, 2500); wr(4, 2500);
    strobe(0);
    expect_gain("R8 frozen after upward error", 2500);
    strobe(60000);
    expect_gain("R8 frozen after downward error", 2500);

    tag = "R9";
    wr(3, 0); wr(4, 6144);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); mag_in = 16'(i * 13000);
    end
    expect_gain("R9 no strobe no change", 2500);

    tag = "R10";
    wr(4, 65535); wr(1, 255); wr(0, 65535);
    strobe(0);
    expect_gain("R10 upper limit saturated at 6144", 6144);
    wr(3, 65535);
    strobe(65535 - 1);
    expect_gain("R10 lower limit saturated at 6144", 6144);

    tag = "R11";
    wr(3, 0); wr(5, 0); wr(1, 64); wr(0, 16384);
    @(negedge clk);
    sample_valid = 1'b1; mag_in = 16'd30000;
    expect_gain("R11 unchanged before edge", 6144);
    @(negedge clk);
    sample_valid = 1'b0;
    expect_gain("R11 updated one cycle after", 6080);

    // Mixed random traffic, compared on every clock against the model
    tag = "R3/R5/R7 random";
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      sample_valid = ($urandom_range(0, 3) != 0);
      mag_in = 16'($urandom_range(0, 40000));
      gain_sel = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 3'($urandom_range(0, 7));
        case (cfg_addr)
          3'd3, 3'd4: cfg_wdata = 16'($urandom_range(0, 7000));
          default:    cfg_wdata = 16'($urandom_range(0, 40000));
        endcase
      end
    end
    @(negedge clk);
    cfg_we = 1'b0; sample_valid = 1'b0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule